// File: doc/BRIEF.md
# Status Word and Write-Permission Guard for a Serial Memory

This block owns the 8-bit status word of a serial nonvolatile memory and decides, cycle by cycle, whether a write request may go ahead. A command decoder in front of it raises single-cycle pulses for "arm writes", "disarm writes" and "status write with data", and presents the byte address of the current array byte. A write timer next to it supplies a busy flag and a one-cycle completion pulse. From these the block produces the status byte for readout, a flag that says a status write would be accepted, and a flag that says the byte at the presented address may be written.

Two mechanisms guard writes. The first is an external active-low protect pin, which is honoured only while a status enable bit is set and which guards only the nonvolatile status bits. The second is a two-bit region field that protects an upper fraction of the address space. Both need the write-arm latch to be set. An accepted status write is staged and only reaches the status word when the timer reports completion. Once a write has been accepted, later changes of the pin have no effect on it. The nonvolatile bits are plain registers here that reset to a parameter value.

Top module: `wprot_status`

## Requirements
- R1: After reset the status byte equals the nonvolatile fields of parameter NV_RESET (default 0x00), with the arm latch (bit 1) clear.
- R2: Status byte layout: bit 7 is the pin-enable bit, bits 3:2 are the region field, bit 1 is the arm latch, and bit 0 follows wip_i in the same cycle. Bits 6:4 always read 0.
- R3: set_wel_i sets the arm latch and clr_wel_i clears it, each visible one cycle later. Both work whatever the protection state or busy flag. When both are high, clear wins.
- R4: sr_wr_ok_o is 1 exactly when the latch is set, wip_i is 0, and the write is not pin-blocked. The write is pin-blocked when bit 7 is 1 and wp_n_i is 0.
- R5: A status write pulse while sr_wr_ok_o is 1 stages bits 7, 3 and 2 of sr_data_i. On the next cycle_done_i these bits appear in the status byte one cycle later. All other data bits are ignored.
- R6: After a status write has been accepted, a change of wp_n_i does not change the value it commits.
- R7: arr_wr_ok_o is 1 exactly when the latch is set, wip_i is 0, and arr_addr_i is outside the protected region. Region codes: 00 protects nothing, 01 protects 0xC00–0xFFF, 10 protects 0x800–0xFFF, and 11 protects every address.
- R8: A cycle_done_i pulse clears the arm latch one cycle later.
- R9: A status write pulse while sr_wr_ok_o is 0 leaves the status byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_wel_i | input | 1 | Arm-writes command pulse |
| clr_wel_i | input | 1 | Disarm-writes command pulse |
| sr_wr_i | input | 1 | Status write request pulse |
| sr_data_i | input | 8 | Byte offered by the status write |
| arr_addr_i | input | ADDR_W | Address of the array byte being written |
| wp_n_i | input | 1 | External write-protect pin, active low |
| wip_i | input | 1 | Internal write cycle busy |
| cycle_done_i | input | 1 | Internal write cycle completion pulse |
| status_o | output | 8 | Status byte |
| sr_wr_ok_o | output | 1 | A status write would be accepted now |
| arr_wr_ok_o | output | 1 | The byte at arr_addr_i may be written |

## Verification
A wrong latch or a wrong region field shows within one cycle, because both are visible in the status byte and gate the two permit flags combinationally. A staged status value that is corrupted stays hidden until the completion pulse, so the bench checks the status byte on the cycle after each completion. It also changes the pin between acceptance and completion. Region edges are probed one address below and at each boundary, under every field code.

// File: rtl/wps_pkg.sv
package wps_pkg;
    localparam int STAT_W   = 8;
    localparam int POS_WPEN = 7;
    localparam int POS_BP_H = 3;
    localparam int POS_BP_L = 2;
    localparam int POS_WEL  = 1;
    localparam int POS_WIP  = 0;

    typedef enum logic [1:0] {
        REG_NONE    = 2'b00,
        REG_QUARTER = 2'b01,
        REG_HALF    = 2'b10,
        REG_ALL     = 2'b11
    } region_e;

    typedef struct packed {
        logic    pin_en;
        region_e region;
    } nv_t;

    function automatic nv_t nv_from_byte(input logic [STAT_W-1:0] b);
        nv_t n;
        n.pin_en = b[POS_WPEN];
        n.region = region_e'(b[POS_BP_H:POS_BP_L]);
        return n;
    endfunction

    function automatic logic [STAT_W-1:0] pack_status(input nv_t n, input logic wel,
                                                      input logic wip);
        logic [STAT_W-1:0] s;
        s = '0;
        s[POS_WPEN] = n.pin_en;
        s[POS_BP_H:POS_BP_L] = n.region;
        s[POS_WEL] = wel;
        s[POS_WIP] = wip;
        return s;
    endfunction
endpackage

// File: rtl/wps_latch.sv
module wps_latch (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    input  logic done_i,
    output logic wel_o
);
    always_ff @(posedge clk) begin
        if (rst)                  wel_o <= 1'b0;
        else if (clr_i || done_i) wel_o <= 1'b0;
        else if (set_i)           wel_o <= 1'b1;
    end
endmodule

// File: rtl/wps_nvreg.sv
module wps_nvreg
    import wps_pkg::*;
#(
    parameter logic [STAT_W-1:0] NV_RESET = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept_i,
    input  logic [STAT_W-1:0] data_i,
    input  logic              done_i,
    output nv_t               nv_o
);
    localparam nv_t NV_INIT = nv_from_byte(NV_RESET);

    nv_t  staged;
    logic pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            nv_o    <= NV_INIT;
            staged  <= NV_INIT;
            pending <= 1'b0;
        end else begin
            if (done_i && pending) nv_o <= staged;
            if (accept_i) begin
                staged  <= nv_from_byte(data_i);
                pending <= 1'b1;
            end else if (done_i) begin
                pending <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/wps_guard.sv
module wps_guard
    import wps_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  nv_t               nv_i,
    input  logic              wel_i,
    input  logic              wip_i,
    input  logic              wp_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              sr_ok_o,
    output logic              arr_ok_o
);
    localparam int TOP = ADDR_W - 1;

    function automatic logic in_region(input region_e r, input logic [ADDR_W-1:0] a);
        case (r)
            REG_NONE:    return 1'b0;
            REG_QUARTER: return &a[TOP:TOP-1];
            REG_HALF:    return a[TOP];
            default:     return 1'b1;
        endcase
    endfunction

    logic armed;
    logic pin_block;

    always_comb begin
        armed     = wel_i && !wip_i;
        pin_block = nv_i.pin_en && !wp_n_i;
        sr_ok_o   = armed && !pin_block;
        arr_ok_o  = armed && !in_region(nv_i.region, addr_i);
    end
endmodule

// File: rtl/wprot_status.sv
module wprot_status
    import wps_pkg::*;
#(
    parameter int                ADDR_W   = 12,
    parameter logic [STAT_W-1:0] NV_RESET = 8'h00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_wel_i,
    input  logic              clr_wel_i,
    input  logic              sr_wr_i,
    input  logic [7:0]        sr_data_i,
    input  logic [ADDR_W-1:0] arr_addr_i,
    input  logic              wp_n_i,
    input  logic              wip_i,
    input  logic              cycle_done_i,
    output logic [7:0]        status_o,
    output logic              sr_wr_ok_o,
    output logic              arr_wr_ok_o
);
    logic wel;
    nv_t  nv;

    wps_latch u_latch (
        .clk(clk), .rst(rst), .set_i(set_wel_i), .clr_i(clr_wel_i),
        .done_i(cycle_done_i), .wel_o(wel)
    );

    wps_nvreg #(.NV_RESET(NV_RESET)) u_nv (
        .clk(clk), .rst(rst), .accept_i(sr_wr_i && sr_wr_ok_o),
        .data_i(sr_data_i), .done_i(cycle_done_i), .nv_o(nv)
    );

    wps_guard #(.ADDR_W(ADDR_W)) u_guard (
        .nv_i(nv), .wel_i(wel), .wip_i(wip_i), .wp_n_i(wp_n_i),
        .addr_i(arr_addr_i), .sr_ok_o(sr_wr_ok_o), .arr_ok_o(arr_wr_ok_o)
    );

    assign status_o = pack_status(nv, wel, wip_i);
endmodule

// File: rtl/wps_checker.sv
module wps_checker #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              set_wel_i,
    input logic              clr_wel_i,
    input logic              cycle_done_i,
    input logic              wp_n_i,
    input logic [ADDR_W-1:0] arr_addr_i,
    input logic [7:0]        status_o,
    input logic              sr_wr_ok_o,
    input logic              arr_wr_ok_o
);
    a_r2_unused_zero: assert property (@(posedge clk) disable iff (rst)
        status_o[6:4] == 3'b000);
    a_r3_clear_wins: assert property (@(posedge clk) disable iff (rst)
        clr_wel_i |=> !status_o[1]);
    a_r3_set_works: assert property (@(posedge clk) disable iff (rst)
        (set_wel_i && !clr_wel_i && !cycle_done_i) |=> status_o[1]);
    a_r4_pin_blocks: assert property (@(posedge clk) disable iff (rst)
        (status_o[7] && !wp_n_i) |-> !sr_wr_ok_o);
    a_r4_needs_latch: assert property (@(posedge clk) disable iff (rst)
        !status_o[1] |-> (!sr_wr_ok_o && !arr_wr_ok_o));
    a_r7_all_locked: assert property (@(posedge clk) disable iff (rst)
        (status_o[3:2] == 2'b11) |-> !arr_wr_ok_o);
    a_r7_top_locked: assert property (@(posedge clk) disable iff (rst)
        (status_o[3:2] != 2'b00 && (&arr_addr_i[ADDR_W-1:ADDR_W-2])) |-> !arr_wr_ok_o);
    a_r8_done_clears: assert property (@(posedge clk) disable iff (rst)
        cycle_done_i |=> !status_o[1]);
    a_r5_commit_only_on_done: assert property (@(posedge clk) disable iff (rst)
        !cycle_done_i |=> $stable({status_o[7], status_o[3:2]}));
endmodule

bind wprot_status wps_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst(rst), .set_wel_i(set_wel_i), .clr_wel_i(clr_wel_i),
    .cycle_done_i(cycle_done_i), .wp_n_i(wp_n_i), .arr_addr_i(arr_addr_i),
    .status_o(status_o), .sr_wr_ok_o(sr_wr_ok_o), .arr_wr_ok_o(arr_wr_ok_o)
);

// File: tb/wprot_status_tb.sv
module wprot_status_tb_top;
    localparam int AW = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic set_wel = 0, clr_wel = 0, sr_wr = 0, wp_n = 1, wip = 0, done = 0;
    logic [7:0] sr_data = '0;
    logic [AW-1:0] addr = '0;
    logic [7:0] status;
    logic sr_ok, arr_ok;

    int checks = 0;
    int fails  = 0;

    logic m_wel = 0, m_pin = 0, m_pend = 0;
    logic [1:0] m_bp = 0;
    logic [7:0] m_stage = 0;

    always #2 clk = ~clk;

    wprot_status #(.ADDR_W(AW), .NV_RESET(8'h00)) dut_i (
        .clk(clk), .rst(rst), .set_wel_i(set_wel), .clr_wel_i(clr_wel),
        .sr_wr_i(sr_wr), .sr_data_i(sr_data), .arr_addr_i(addr), .wp_n_i(wp_n),
        .wip_i(wip), .cycle_done_i(done), .status_o(status),
        .sr_wr_ok_o(sr_ok), .arr_wr_ok_o(arr_ok)
    );

    function automatic logic exp_region(input logic [1:0] bp, input logic [AW-1:0] a);
        if (bp == 2'b00) return 1'b0;
        if (bp == 2'b01) return a >= 12'hC00;
        if (bp == 2'b10) return a >= 12'h800;
        return 1'b1;
    endfunction

    function automatic logic [7:0] exp_status();
        return {m_pin, 3'b000, m_bp, m_wel, wip};
    endfunction

    function automatic logic exp_sr_ok();
        return m_wel && !wip && !(m_pin && !wp_n);
    endfunction

    function automatic logic exp_arr_ok();
        return m_wel && !wip && !exp_region(m_bp, addr);
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic step(input logic s, input logic c, input logic w, input logic [7:0] d,
                        input logic [AW-1:0] a, input logic p, input logic busy,
                        input logic dn, input string tag);
        logic acc;
        @(negedge clk);
        set_wel = s; clr_wel = c; sr_wr = w; sr_data = d;
        addr = a; wp_n = p; wip = busy; done = dn;
        #1;
        chk({tag, " R2 status"}, status, exp_status());
        chk({tag, " R4 sr_ok"}, {7'd0, sr_ok}, {7'd0, exp_sr_ok()});
        chk({tag, " R7 arr_ok"}, {7'd0, arr_ok}, {7'd0, exp_arr_ok()});
        acc = w && exp_sr_ok();
        @(posedge clk);
        if (dn && m_pend) begin
            m_pin = m_stage[7];
            m_bp  = m_stage[3:2];
        end
        if (acc) begin
            m_stage = d;
            m_pend  = 1'b1;
        end else if (dn) begin
            m_pend = 1'b0;
        end
        if (c || dn) m_wel = 1'b0;
        else if (s)  m_wel = 1'b1;
    endtask

    // Accept a status write and complete it.
    task automatic wr_status(input logic [7:0] d, input string tag);
        step(1, 0, 0, 0, 0, 1, 0, 0, tag);
        step(0, 0, 1, d, 0, 1, 0, 0, tag);
        step(0, 0, 0, 0, 0, 1, 1, 0, tag);
        step(0, 0, 0, 0, 0, 1, 1, 1, tag);
        step(0, 0, 0, 0, 0, 1, 0, 0, tag);
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [AW-1:0] edges [6];
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        chk("R1 reset status", status, 8'h00);
        chk("R1 reset sr_ok", {7'd0, sr_ok}, 8'h00);

        // R3: set then clear, and both together (clear wins)
        step(1, 0, 0, 0, 0, 1, 0, 0, "R3 set");
        step(0, 1, 0, 0, 0, 1, 0, 0, "R3 clr");
        step(1, 1, 0, 0, 0, 1, 0, 0, "R3 both");
        step(0, 0, 0, 0, 0, 1, 0, 0, "R3 after both");
        // R3: set works while busy
        step(1, 0, 0, 0, 0, 1, 1, 0, "R3 set busy");
        step(0, 0, 0, 0, 0, 1, 1, 0, "R3 busy view");
        // R8: completion clears latch
        step(0, 0, 0, 0, 0, 1, 1, 1, "R8 done");
        step(0, 0, 0, 0, 0, 1, 0, 0, "R8 after");

        // R5: only bits 7,3,2 land; enable pin and region 01
        wr_status(8'hF5, "R5 commit");
        chk("R5 field", status, 8'h84);

        // R7: region boundaries under each code
        edges[0] = 12'h000; edges[1] = 12'h7FF; edges[2] = 12'h800;
        edges[3] = 12'hBFF; edges[4] = 12'hC00; edges[5] = 12'hFFF;
        for (int b = 0; b < 4; b++) begin
            wr_status({1'b0, 4'b0, b[1:0], 2'b0}, "R7 region set");
            step(1, 0, 0, 0, 0, 1, 0, 0, "R7 arm");
            for (int e = 0; e < 6; e++)
                step(0, 0, 0, 0, edges[e], 1, 0, 0, "R7 edge");
            step(0, 1, 0, 0, 0, 1, 0, 0, "R7 disarm");
        end

        // R4/R9: pin-blocked status write is refused and leaves status unchanged
        wr_status(8'h80, "R4 enable pin");
        step(1, 0, 0, 0, 0, 0, 0, 0, "R9 arm");
        step(0, 0, 1, 8'h0C, 0, 0, 0, 0, "R9 refused");
        step(0, 0, 0, 0, 0, 0, 1, 1, "R9 done");
        step(0, 0, 0, 0, 0, 1, 0, 0, "R9 after");
        chk("R9 unchanged", status, 8'h80);

        // R6: pin falls after acceptance; commit still lands
        step(1, 0, 0, 0, 0, 1, 0, 0, "R6 arm");
        step(0, 0, 1, 8'h88, 0, 1, 0, 0, "R6 accept");
        step(0, 0, 0, 0, 0, 0, 1, 0, "R6 pin low");
        step(0, 0, 0, 0, 0, 0, 1, 1, "R6 done");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R6 after");
        chk("R6 committed", status, 8'h88);

        // Constrained random mix
        void'($urandom(32'd2024));
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom();
            step(r[2:0] == 0, r[5:3] == 0, r[8:6] < 2, r[16:9], $urandom() % 4096,
                 r[19:17] != 0, r[21:20] == 0, r[24:22] == 0, "rand");
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule